// File: doc/BRIEF.md
# Doorbell Interrupt Unit

This block keeps a 32-bit pending-doorbell word and a 32-bit enable word for each processor. A single global trigger write names a doorbell number and a bitmap of target processors. The unit then raises that doorbell bit in every processor the bitmap names. Doorbells 0 to 7 serve as inter-processor interrupts. Doorbells 16 to 31 serve as message-signalled interrupts, which a bus master raises by writing one data word to the trigger location. Doorbells 8 to 15 are not implemented.

Each processor owns two registers. The pending word is cleared by writing zeros: software writes the inverse of the bits it has serviced, and a write of all zeros flushes everything at start-up. The enable word is written directly. For each processor the unit drives two summary lines, one for the inter-processor group and one for the message group. These lines feed the first two sources of a downstream interrupt router.

Top module: `doorbell_unit`

## Requirements
- R1: After synchronous reset every pending word and every enable word reads zero, and every summary line is low.
- R2: A trigger write takes the doorbell number from bits [4:0] and the target bitmap from bits [8+NUM_CPUS-1:8], with bit 8+c meaning processor c. It sets pending bit n of each named processor at the next clock edge. Unnamed processors and all other bits are unchanged.
- R3: A trigger write whose doorbell number is in the range 8 to 15 changes nothing. Pending bits 8 to 15 always read zero.
- R4: A pending-word write to processor c clears each bit where the written data holds 0 and leaves each bit where it holds 1 unchanged. A write of zero therefore clears all pending bits.
- R5: An enable-word write to processor c replaces that processor's enable word and no other.
- R6: The inter-processor line of processor c is high exactly when some bit in 0..7 is set in both its pending word and its enable word.
- R7: The message line of processor c is high exactly when some bit in 16..31 is set in both its pending word and its enable word.
- R8: When a trigger and a pending-word write touch the same bit in the same cycle, the bit ends up set.
- R9: A trigger word of 0xF00 | (16+k) sets pending bit 16+k in all four processors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_we | input | 1 | Trigger register write strobe |
| trig_data | input | 32 | Trigger word: target bitmap at [8+NUM_CPUS-1:8], doorbell number at [4:0] |
| cpu_we | input | 1 | Per-processor register write strobe |
| cpu_sel | input | SEL_W | Processor whose register is written |
| cpu_reg_mask | input | 1 | 1 selects the enable word, 0 the pending word |
| cpu_wdata | input | 32 | Per-processor write data |
| cause_q | output | NUM_CPUS*32 | Pending words, processor c at [c*32 +: 32] |
| mask_q | output | NUM_CPUS*32 | Enable words, processor c at [c*32 +: 32] |
| ipi_irq | output | NUM_CPUS | Inter-processor summary line per processor |
| msi_irq | output | NUM_CPUS | Message summary line per processor |

## Verification
The bench fires a trigger and a clearing write of zero at the same bit in one cycle. A design that let the clear win would drop that doorbell. It sends doorbell numbers 8 and 15, which a design without the range check would latch into the gap bits. It writes a pending word with all ones, and with the inverse of a single serviced bit. A design that treated the write as a plain store, or as write-one-to-clear, would wipe or keep the wrong bits. It also leaves a bit pending while it is disabled, then enables it. This shows whether a summary line ignores the enable word or takes bits from the wrong group.

// File: rtl/db_pkg.sv
package db_pkg;

    localparam int DB_W    = 32;
    localparam int NUM_W   = 5;
    localparam int MAP_LSB = 8;

    localparam logic [DB_W-1:0] IPI_FIELD  = 32'h0000_00FF;
    localparam logic [DB_W-1:0] MSI_FIELD  = 32'hFFFF_0000;
    localparam logic [DB_W-1:0] IMPL_FIELD = IPI_FIELD | MSI_FIELD;

    typedef logic [DB_W-1:0] db_vec_t;

    typedef struct packed {
        logic             valid;
        logic [NUM_W-1:0] num;
    } db_hit_t;

    function automatic logic db_num_ok(logic [NUM_W-1:0] n);
        return IMPL_FIELD[n];
    endfunction

endpackage

// File: rtl/db_trig_decode.sv
module db_trig_decode
    import db_pkg::*;
#(
    parameter int NUM_CPUS = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   trig_we,
    input  db_vec_t                trig_data,
    output db_vec_t [NUM_CPUS-1:0] set_o
);

    db_hit_t hit;
    db_vec_t onehot;

    always_comb begin
        hit.num   = trig_data[NUM_W-1:0];
        hit.valid = trig_we && db_num_ok(hit.num);
        onehot    = '0;
        if (hit.valid) onehot[hit.num] = 1'b1;
    end

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_target
        assign set_o[c] = trig_data[MAP_LSB + c] ? onehot : '0;

        // R2: a single trigger raises at most one doorbell per processor
        assert_single_bit_R2: assert property (@(posedge clk) disable iff (rst)
            $onehot0(set_o[c]));
    end

    // R3: numbers in the unimplemented gap produce no set request
    assert_gap_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (trig_data[NUM_W-1:3] == 2'b01) |-> (set_o == '0));

endmodule

// File: rtl/db_summary.sv
module db_summary
    import db_pkg::*;
(
    input  db_vec_t cause_i,
    input  db_vec_t mask_i,
    output logic    ipi_o,
    output logic    msi_o
);

    db_vec_t live;

    always_comb begin
        live  = cause_i & mask_i;
        ipi_o = |(live & IPI_FIELD);
        msi_o = |(live & MSI_FIELD);
    end

endmodule

// File: rtl/db_cpu_bank.sv
module db_cpu_bank
    import db_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  db_vec_t set_i,
    input  logic    cause_we,
    input  logic    mask_we,
    input  db_vec_t wdata,
    output db_vec_t cause_o,
    output db_vec_t mask_o,
    output logic    ipi_o,
    output logic    msi_o
);

    db_vec_t cause_r;
    db_vec_t mask_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_r <= '0;
            mask_r  <= '0;
        end else begin
            if (cause_we) cause_r <= (cause_r & wdata) | set_i;
            else          cause_r <= cause_r | set_i;
            if (mask_we)  mask_r  <= wdata;
        end
    end

    assign cause_o = cause_r;
    assign mask_o  = mask_r;

    db_summary i_summary (
        .cause_i (cause_r),
        .mask_i  (mask_r),
        .ipi_o   (ipi_o),
        .msi_o   (msi_o)
    );

    // R2, R8: every requested set is visible after the edge, even under a clear
    assert_set_lands_R8: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((cause_r & $past(set_i)) == $past(set_i)));

    // R4: a clearing write never raises a bit that was not requested
    assert_clear_only_R4: assert property (@(posedge clk) disable iff (rst)
        (cause_we && set_i == '0) |=> ((cause_r & ~$past(cause_r)) == '0));

    // R4: without writes or triggers the pending word holds
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!cause_we && set_i == '0) |=> $stable(cause_r));

    // R5: the enable word changes only on its own write
    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(mask_r));

    // R3: the gap bits stay clear
    assert_gap_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (cause_r & ~IMPL_FIELD) == '0);

endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
    import db_pkg::*;
#(
    parameter  int NUM_CPUS = 4,
    localparam int SEL_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     trig_we,
    input  logic [DB_W-1:0]          trig_data,
    input  logic                     cpu_we,
    input  logic [SEL_W-1:0]         cpu_sel,
    input  logic                     cpu_reg_mask,
    input  logic [DB_W-1:0]          cpu_wdata,
    output logic [NUM_CPUS*DB_W-1:0] cause_q,
    output logic [NUM_CPUS*DB_W-1:0] mask_q,
    output logic [NUM_CPUS-1:0]      ipi_irq,
    output logic [NUM_CPUS-1:0]      msi_irq
);

    db_vec_t [NUM_CPUS-1:0] set_vec;

    db_trig_decode #(.NUM_CPUS(NUM_CPUS)) i_decode (
        .clk       (clk),
        .rst       (rst),
        .trig_we   (trig_we),
        .trig_data (trig_data),
        .set_o     (set_vec)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        logic    hit_sel;
        db_vec_t cause_w;
        db_vec_t mask_w;

        assign hit_sel = cpu_we && (cpu_sel == SEL_W'(c));

        db_cpu_bank i_bank (
            .clk      (clk),
            .rst      (rst),
            .set_i    (set_vec[c]),
            .cause_we (hit_sel && !cpu_reg_mask),
            .mask_we  (hit_sel &&  cpu_reg_mask),
            .wdata    (cpu_wdata),
            .cause_o  (cause_w),
            .mask_o   (mask_w),
            .ipi_o    (ipi_irq[c]),
            .msi_o    (msi_irq[c])
        );

        assign cause_q[c*DB_W +: DB_W] = cause_w;
        assign mask_q[c*DB_W +: DB_W]  = mask_w;
    end

endmodule

// File: tb/test_doorbell_unit.sv
`timescale 1ns/1ps
module test_doorbell_unit;

    localparam int N = 4;

    typedef struct packed {
        logic [1:0]  kind;   // 0 trigger, 1 pending write, 2 enable write
        logic [1:0]  sel;
        logic [31:0] data;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TABLE [NV] = '{
        '{2'd2, 2'd0, 32'hFFFF_FFFF, 4'd5},
        '{2'd2, 2'd1, 32'h0000_00FF, 4'd5},
        '{2'd2, 2'd2, 32'hFFFF_0000, 4'd5},
        '{2'd0, 2'd0, 32'h0000_0302, 4'd2},
        '{2'd0, 2'd0, 32'h0000_0F15, 4'd9},
        '{2'd0, 2'd0, 32'h0000_040A, 4'd3},
        '{2'd0, 2'd0, 32'h0000_0807, 4'd2},
        '{2'd2, 2'd3, 32'h0000_0080, 4'd6},
        '{2'd1, 2'd0, 32'hFFFF_FFFB, 4'd4},
        '{2'd0, 2'd0, 32'h0000_0003, 4'd2},
        '{2'd0, 2'd0, 32'h0000_0F1F, 4'd9},
        '{2'd1, 2'd1, 32'h0000_0000, 4'd4},
        '{2'd1, 2'd2, 32'hFFFF_FFFF, 4'd4},
        '{2'd2, 2'd2, 32'h0000_0000, 4'd7}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig_we = 1'b0;
    logic [31:0]   trig_data = '0;
    logic          cpu_we = 1'b0;
    logic [1:0]    cpu_sel = '0;
    logic          cpu_reg_mask = 1'b0;
    logic [31:0]   cpu_wdata = '0;
    logic [N*32-1:0] cause_q, mask_q;
    logic [N-1:0]  ipi_irq, msi_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] m_cause [N];
    logic [31:0] m_mask  [N];

    always #2.5 clk = ~clk;

    doorbell_unit #(.NUM_CPUS(N)) i_doorbell_unit (
        .clk (clk), .rst (rst), .trig_we (trig_we), .trig_data (trig_data),
        .cpu_we (cpu_we), .cpu_sel (cpu_sel), .cpu_reg_mask (cpu_reg_mask),
        .cpu_wdata (cpu_wdata), .cause_q (cause_q), .mask_q (mask_q),
        .ipi_irq (ipi_irq), .msi_irq (msi_irq)
    );

    function automatic string tag_name(logic [3:0] t);
        case (t)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] trig_sets(int c, logic [31:0] d);
        logic [31:0] s = '0;
        logic [4:0]  n = d[4:0];
        if (!(n >= 5'd8 && n <= 5'd15) && d[8+c]) s[n] = 1'b1;
        return s;
    endfunction

    task automatic check_all(input string req);
        for (int c = 0; c < N; c++) begin
            logic [31:0] ca = cause_q[c*32 +: 32];
            logic [31:0] ma = mask_q[c*32 +: 32];
            logic ei = |(m_cause[c] & m_mask[c] & 32'h0000_00FF);
            logic em = |(m_cause[c] & m_mask[c] & 32'hFFFF_0000);
            check(ca == m_cause[c], req, $sformatf("cause cpu%0d", c), ca, m_cause[c]);
            check(ma == m_mask[c], "R5", $sformatf("mask cpu%0d", c), ma, m_mask[c]);
            check(ipi_irq[c] == ei, "R6", $sformatf("ipi cpu%0d", c),
                  {31'd0, ipi_irq[c]}, {31'd0, ei});
            check(msi_irq[c] == em, "R7", $sformatf("msi cpu%0d", c),
                  {31'd0, msi_irq[c]}, {31'd0, em});
        end
    endtask

    task automatic do_vec(input vec_t v);
        @(negedge clk);
        if (v.kind == 2'd0) begin
            trig_we = 1'b1; trig_data = v.data;
            for (int c = 0; c < N; c++) m_cause[c] |= trig_sets(c, v.data);
        end else begin
            cpu_we = 1'b1; cpu_sel = v.sel; cpu_wdata = v.data;
            cpu_reg_mask = (v.kind == 2'd2);
            if (v.kind == 2'd2) m_mask[v.sel] = v.data;
            else                m_cause[v.sel] &= v.data;
        end
        @(posedge clk);
        @(negedge clk);
        trig_we = 1'b0; cpu_we = 1'b0;
        check_all(tag_name(v.tag));
    endtask

    task automatic model_reset();
        for (int c = 0; c < N; c++) begin
            m_cause[c] = '0; m_mask[c] = '0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check_all("R1");

        for (int i = 0; i < NV; i++) do_vec(TABLE[i]);

        // R3: numbers 8 and 15 to all processors are dropped
        do_vec('{2'd0, 2'd0, 32'h0000_0F08, 4'd3});
        do_vec('{2'd0, 2'd0, 32'h0000_0F0F, 4'd3});

        // R9: every message number reaches all four processors
        for (int k = 0; k < 16; k++)
            do_vec('{2'd0, 2'd0, 32'h0000_0F00 | (32'd16 + k), 4'd9});

        // R4: write zero clears all of cpu0
        do_vec('{2'd1, 2'd0, 32'h0000_0000, 4'd4});

        // R8: set and clear of the same bit in the same cycle
        @(negedge clk);
        trig_we = 1'b1; trig_data = 32'h0000_0103;
        cpu_we = 1'b1; cpu_sel = 2'd0; cpu_reg_mask = 1'b0; cpu_wdata = 32'h0;
        m_cause[0] = (m_cause[0] & 32'h0) | 32'h0000_0008;
        @(posedge clk);
        @(negedge clk);
        trig_we = 1'b0; cpu_we = 1'b0;
        check(cause_q[31:0] == 32'h0000_0008, "R8", "set beats clear",
              cause_q[31:0], 32'h0000_0008);
        check_all("R8");

        // R1: reset in mid-run returns everything to zero
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_all("R1");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule